// File: doc/BRIEF.md
# I2C Byte Transmitter with Acknowledge-Gated Completion Flags

This block is the sending half of a bus-master byte engine for a two-wire serial bus. Software, or a DMA engine acting on its behalf, writes a byte into the data register. The block then issues a start condition if the bus is idle and shifts the byte out on SDA, most significant bit first. It generates SCL itself from the system clock through a programmable divider. On the ninth clock it releases SDA and samples the receiver's acknowledge bit.

When a byte finishes, the block raises up to three flags: buffer-empty, interrupt and transfer-request. Which of them it raises depends on a judgement-enable control bit and on the sampled acknowledge. The transfer-request flag drives a DMA request line. When the DMA reports with a done pulse that its programmed count is complete, all three flags are cleared, so a DMA-fed stream runs without interrupting the CPU. With judgement enabled, a NACK raises only the interrupt flag. The DMA then stops being requested and the CPU takes over through the interrupt line.

The bus lines are modelled as open-drain lines. Each has an output-enable that pulls the line low, and SDA is also read back as an input. A stop condition is sent only when software asks for one.

Top module: `i2c_atx`

## Requirements
- R1: After reset the flags read buffer-empty=1, interrupt=0, transfer-request=0 (flags_o = 3'b001, bit 0 empty, bit 1 interrupt, bit 2 request). Judgement and interrupt enable are 0, both bus lines are released, and irq, dreq and ack_stat_o are 0.
- R2: Writing address 0 with the bus idle sends one start condition (SDA falls while SCL is high). The 8 data bits follow MSB first, one per SCL pulse, then a ninth pulse with SDA released for the acknowledge.
- R3: Each SCL period lasts 2*(D+1) system clocks, where D is the divider written at address 3 (low DIV_W bits).
- R4: With judgement enable (address 1 bit 0) at 0, a completed byte sets all three flags whatever the acknowledge value, and ack_stat_o reads 0.
- R5: With judgement enable at 1 and acknowledge 0, a completed byte sets all three flags and ack_stat_o reads 0.
- R6: With judgement enable at 1 and acknowledge 1, a completed byte sets only the interrupt flag, leaves transfer-request at 0 so dreq stays low, and ack_stat_o reads 1.
- R7: dreq follows the transfer-request flag.
- R8: A one-cycle ddone pulse clears all three flags; a flag set by a byte completing in the same cycle takes priority over the clear.
- R9: irq is high exactly when the interrupt flag is set and interrupt enable (address 1 bit 1) is 1.
- R10: A write to address 0 clears buffer-empty. A write to address 2 clears each flag whose bit is 0 in the written value and leaves flags whose bit is 1 unchanged.
- R11: Writing address 1 with bit 2 set requests a stop. After the current byte, SDA rises while SCL is high, and then both lines stay released.
- R12: Outside start and stop conditions, SDA changes only while SCL is held low.
- R13: A byte written while the previous byte is still on the bus, or while the bus is held after a byte, is sent right after it with no new start condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 data, 1 control, 2 flag clear, 3 divider |
| wr_data | input | 8 | Register write data |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |
| irq | output | 1 | Interrupt request |
| dreq | output | 1 | DMA transfer request |
| ddone | input | 1 | DMA transfer-count-complete pulse |
| flags_o | output | 3 | Flags: bit 0 buffer-empty, bit 1 interrupt, bit 2 transfer-request |
| ack_stat_o | output | 1 | Reported acknowledge value |

## Verification
The bench builds the block with a 4-bit divider, which keeps every SCL period short enough to run a full sweep. It covers all four divider settings from 0 to 3 against all four combinations of judgement enable and receiver acknowledge. That is sixteen framed bytes, each ended by a stop, with the flag pattern, SCL period and received byte computed arithmetically for each case. Divider 0, where a tick comes every cycle, reaches the tightest acknowledge timing. A further sequence covers back-to-back bytes, clear-by-zero writes and the DMA done clear.

// File: rtl/i2c_atx_pkg.sv
package i2c_atx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_BLO, ST_BHI, ST_ALO, ST_AHI, ST_HOLD, ST_PLO, ST_PHI
  } st_t;

  localparam int F_EMPTY = 0;
  localparam int F_INT   = 1;
  localparam int F_REQ   = 2;
  localparam int NFLAGS  = 3;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_FCLR = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;
endpackage

// File: rtl/i2c_atx_tick.sv
module i2c_atx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_atx_seq.sv
module i2c_atx_seq
  import i2c_atx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pend,
  input  logic          stop_req,
  input  logic [DW-1:0] tx_byte,
  input  logic          sda_in,
  output logic          load,
  output logic          stop_take,
  output logic          byte_done,
  output logic          ack_bit,
  output logic          scl_oe,
  output logic          sda_oe,
  output st_t           state
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  st_t            st_q, st_d;
  logic [DW-1:0]  sh_q, sh_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic           ack_q, ack_d;

  always_comb begin
    st_d      = st_q;
    sh_d      = sh_q;
    cnt_d     = cnt_q;
    ack_d     = ack_q;
    load      = 1'b0;
    stop_take = 1'b0;
    byte_done = 1'b0;
    if (tick) begin
      unique case (st_q)
        ST_IDLE: if (pend) begin
          st_d = ST_START;
          load = 1'b1;
          sh_d = tx_byte;
        end
        ST_START: begin
          st_d  = ST_BLO;
          cnt_d = LAST;
        end
        ST_BLO: st_d = ST_BHI;
        ST_BHI: begin
          if (cnt_q == '0) st_d = ST_ALO;
          else begin
            cnt_d = cnt_q - 1'b1;
            sh_d  = {sh_q[DW-2:0], 1'b0};
            st_d  = ST_BLO;
          end
        end
        ST_ALO: begin
          st_d  = ST_AHI;
          ack_d = sda_in;
        end
        ST_AHI: begin
          st_d      = ST_HOLD;
          byte_done = 1'b1;
        end
        ST_HOLD: begin
          if (pend) begin
            st_d  = ST_BLO;
            load  = 1'b1;
            sh_d  = tx_byte;
            cnt_d = LAST;
          end else if (stop_req) begin
            st_d      = ST_PLO;
            stop_take = 1'b1;
          end
        end
        ST_PLO:  st_d = ST_PHI;
        ST_PHI:  st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      cnt_q <= '0;
      ack_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      ack_q <= ack_d;
    end
  end

  assign ack_bit = ack_q;
  assign state   = st_q;
  assign scl_oe  = (st_q == ST_BLO) || (st_q == ST_ALO) ||
                   (st_q == ST_HOLD) || (st_q == ST_PLO);
  assign sda_oe  = (st_q == ST_START) || (st_q == ST_PLO) || (st_q == ST_PHI) ||
                   (((st_q == ST_BLO) || (st_q == ST_BHI)) && !sh_q[DW-1]);
endmodule

// File: rtl/i2c_atx_flags.sv
module i2c_atx_flags
  import i2c_atx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_done,
  input  logic              ack_bit,
  input  logic              ajen,
  input  logic              ddone,
  input  logic              data_wr,
  input  logic              fclr_wr,
  input  logic [NFLAGS-1:0] fclr_val,
  output logic [NFLAGS-1:0] flags,
  output logic              ack_stat
);
  logic [NFLAGS-1:0] fl_q, fl_d, set_m, clr_m;
  logic              ack_q, ack_d;

  always_comb begin
    clr_m = '0;
    if (ddone)   clr_m = '1;
    if (fclr_wr) clr_m = clr_m | ~fclr_val;
    if (data_wr) clr_m[F_EMPTY] = 1'b1;

    set_m = '0;
    if (byte_done) begin
      set_m[F_INT] = 1'b1;
      if (!ajen || !ack_bit) begin
        set_m[F_EMPTY] = 1'b1;
        set_m[F_REQ]   = 1'b1;
      end
    end

    fl_d  = (fl_q & ~clr_m) | set_m;
    ack_d = byte_done ? (ajen & ack_bit) : ack_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_q  <= NFLAGS'(1) << F_EMPTY;
      ack_q <= 1'b0;
    end else begin
      fl_q  <= fl_d;
      ack_q <= ack_d;
    end
  end

  assign flags    = fl_q;
  assign ack_stat = ack_q & ajen;
endmodule

// File: rtl/i2c_atx.sv
module i2c_atx
  import i2c_atx_pkg::*;
#(
  parameter int               DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(4)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic        scl_oe,
  output logic        sda_oe,
  input  logic        sda_in,
  output logic        irq,
  output logic        dreq,
  input  logic        ddone,
  output logic [2:0]  flags_o,
  output logic        ack_stat_o
);
  localparam int DW = 8;
  localparam int DL = (DIV_W < DW) ? DIV_W : DW;

  logic [1:0] rs_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  logic [DW-1:0]    tx_q, tx_d;
  logic             pend_q, pend_d;
  logic             ajen_q, ajen_d;
  logic             ien_q, ien_d;
  logic             stop_q, stop_d;
  logic [DIV_W-1:0] div_q, div_d;

  logic data_wr, ctrl_wr, fclr_wr, div_wr;
  logic tick, load, stop_take, byte_done, ack_bit;
  st_t  state;

  assign data_wr = wr_en && (wr_addr == A_DATA);
  assign ctrl_wr = wr_en && (wr_addr == A_CTRL);
  assign fclr_wr = wr_en && (wr_addr == A_FCLR);
  assign div_wr  = wr_en && (wr_addr == A_DIV);

  always_comb begin
    tx_d   = data_wr ? wr_data : tx_q;
    pend_d = data_wr ? 1'b1 : (load ? 1'b0 : pend_q);
    ajen_d = ctrl_wr ? wr_data[0] : ajen_q;
    ien_d  = ctrl_wr ? wr_data[1] : ien_q;
    div_d  = div_q;
    if (div_wr) div_d = DIV_W'(wr_data[DL-1:0]);
    if (ctrl_wr && wr_data[2])                stop_d = 1'b1;
    else if (stop_take || (state == ST_IDLE)) stop_d = 1'b0;
    else                                      stop_d = stop_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      tx_q   <= '0;
      pend_q <= 1'b0;
      ajen_q <= 1'b0;
      ien_q  <= 1'b0;
      stop_q <= 1'b0;
      div_q  <= DIV_RST;
    end else begin
      tx_q   <= tx_d;
      pend_q <= pend_d;
      ajen_q <= ajen_d;
      ien_q  <= ien_d;
      stop_q <= stop_d;
      div_q  <= div_d;
    end
  end

  i2c_atx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk   (clk),
    .rst_n (rst_sn),
    .run   ((state != ST_IDLE) || pend_q),
    .div   (div_q),
    .tick  (tick)
  );

  i2c_atx_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sn),
    .tick      (tick),
    .pend      (pend_q),
    .stop_req  (stop_q),
    .tx_byte   (tx_q),
    .sda_in    (sda_in),
    .load      (load),
    .stop_take (stop_take),
    .byte_done (byte_done),
    .ack_bit   (ack_bit),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .state     (state)
  );

  i2c_atx_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_sn),
    .byte_done (byte_done),
    .ack_bit   (ack_bit),
    .ajen      (ajen_q),
    .ddone     (ddone),
    .data_wr   (data_wr),
    .fclr_wr   (fclr_wr),
    .fclr_val  (wr_data[NFLAGS-1:0]),
    .flags     (flags_o),
    .ack_stat  (ack_stat_o)
  );

  assign dreq = flags_o[F_REQ];
  assign irq  = flags_o[F_INT] & ien_q;
endmodule

// File: rtl/i2c_atx_chk.sv
module i2c_atx_chk
  import i2c_atx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ddone,
  input logic       byte_done,
  input logic       ajen,
  input logic       ack_bit,
  input logic [2:0] flags,
  input logic       dreq,
  input logic       irq,
  input logic       ien,
  input logic       ack_stat,
  input logic       scl_oe,
  input logic       sda_oe,
  input st_t        state
);
  AST_REQ_WITH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq) |-> (flags[F_EMPTY] && flags[F_INT])); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags[F_INT] && ien)); // R9

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ddone && !byte_done) |=> (flags == 3'b000)); // R8

  AST_NOJUDGE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !ajen) |=> (flags == 3'b111)); // R4

  AST_ACK0_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !ack_bit) |=> (flags == 3'b111)); // R5

  AST_NACK_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ajen && ack_bit) |=> (flags[F_INT] && (!ajen || ack_stat))); // R6

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && (sda_oe != $past(sda_oe)))
      |-> ((state == ST_START) || ($past(state) == ST_PHI))); // R12
endmodule

bind i2c_atx i2c_atx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_sn),
  .ddone     (ddone),
  .byte_done (byte_done),
  .ajen      (ajen_q),
  .ack_bit   (ack_bit),
  .flags     (flags_o),
  .dreq      (dreq),
  .irq       (irq),
  .ien       (ien_q),
  .ack_stat  (ack_stat_o),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .state     (state)
);

// File: tb/i2c_atx_tb.sv
module i2c_atx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       ddone = 1'b0;
  logic       slv_low = 1'b0;
  logic       ack_mode = 1'b0;
  wire        scl_oe, sda_oe, irq, dreq, ack_stat;
  wire  [2:0] flags;
  wire        sda_in = !(sda_oe | slv_low);

  always #2 clk = ~clk;

  i2c_atx #(.DIV_W(4), .DIV_RST(4'd3)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in), .irq(irq), .dreq(dreq),
    .ddone(ddone), .flags_o(flags), .ack_stat_o(ack_stat)
  );

  int checks = 0, errors = 0, cyc = 0;
  int starts = 0, stops = 0, nbytes = 0, bitn = 0, last_rise = 0, gap = 0;
  logic [7:0] rx = '0, last_byte = '0;
  logic pscl = 1'b1, psda = 1'b1;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor and receiver model
  always @(negedge clk) begin
    logic scl, sda;
    scl = !scl_oe;
    sda = sda_in;
    if (pscl && scl && psda && !sda) begin starts++; bitn = 0; end
    if (pscl && scl && !psda && sda) stops++;
    if (!pscl && scl) begin
      gap = cyc - last_rise;
      last_rise = cyc;
      if (bitn == 8) begin nbytes++; last_byte = rx; bitn = 0; end
      else begin rx = {rx[6:0], sda}; bitn++; end
    end
    if (pscl && !scl) slv_low = (bitn == 8) && !ack_mode;
    pscl = scl;
    psda = sda;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    ddone = 1'b1;
    @(negedge clk);
    ddone = 1'b0;
  endtask

  task automatic wait_intf(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (flags[1]) begin ok = 1; break; end
    end
  endtask

  task automatic wait_stop(input int s0, output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (stops > s0) begin ok = 1; break; end
    end
  endtask

  initial begin
    bit ok;
    int s0;
    logic [2:0] expf;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(flags == 3'b001, "R1 flags", flags, 1);
    chk(!irq && !dreq && !ack_stat, "R1 irq/dreq/ack", {irq, dreq, ack_stat}, 0);
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);

    for (int d = 0; d < 4; d++) begin
      for (int j = 0; j < 2; j++) begin
        for (int k = 0; k < 2; k++) begin
          logic ien;
          b = 8'(8'h5A + d * 37 + j * 91 + k * 19);
          ien = logic'(j ^ k ^ d[0]);
          ack_mode = logic'(k);
          wr(2'd3, 8'(d));
          wr(2'd1, {5'b0, 1'b0, ien, logic'(j)});
          pulse_done();
          chk(flags == 3'b000, "R8 done clear", flags, 0);
          s0 = starts;
          wr(2'd0, b);
          chk(flags[0] == 1'b0, "R10 data write clears empty", flags, 0);
          wait_intf(ok);
          chk(ok, "R2 byte completion", ok, 1);
          chk(last_byte == b, "R2 byte MSB first", last_byte, b);
          chk(starts == s0 + 1, "R2 one start", starts - s0, 1);
          chk(gap == 2 * (d + 1), "R3 SCL period", gap, 2 * (d + 1));
          expf = (j == 0 || k == 0) ? 3'b111 : 3'b010;
          if (j == 0) begin
            chk(flags == expf, "R4 flags", flags, expf);
            chk(ack_stat == 1'b0, "R4 ack_stat", ack_stat, 0);
          end else if (k == 0) begin
            chk(flags == expf, "R5 flags", flags, expf);
            chk(ack_stat == 1'b0, "R5 ack_stat", ack_stat, 0);
          end else begin
            chk(flags == expf, "R6 flags", flags, expf);
            chk(ack_stat == 1'b1, "R6 ack_stat", ack_stat, 1);
            chk(dreq == 1'b0, "R6 no dreq", dreq, 0);
          end
          chk(dreq == expf[2], "R7 dreq", dreq, expf[2]);
          chk(irq == ien, "R9 irq", irq, ien);
          s0 = stops;
          wr(2'd1, {5'b0, 1'b1, ien, logic'(j)});
          wait_stop(s0, ok);
          chk(ok, "R11 stop seen", ok, 1);
          repeat (2) @(negedge clk);
          chk(!scl_oe && !sda_oe, "R11 released", {scl_oe, sda_oe}, 0);
        end
      end
    end

    // back-to-back bytes, clear-by-zero, DMA done
    ack_mode = 1'b0;
    wr(2'd3, 8'd1);
    wr(2'd1, 8'b0000_0010);
    pulse_done();
    s0 = starts;
    wr(2'd0, 8'hC3);
    wait_intf(ok);
    chk(ok && last_byte == 8'hC3, "R13 first byte", last_byte, 8'hC3);
    wr(2'd2, 8'b0000_0101);
    chk(flags == 3'b101, "R10 clear-by-zero", flags, 5);
    chk(irq == 1'b0, "R9 irq low after clear", irq, 0);
    wr(2'd0, 8'h3E);
    chk(flags == 3'b100, "R10 empty cleared", flags, 4);
    wr(2'd0, 8'h81);
    wait_intf(ok);
    chk(ok && last_byte == 8'h3E, "R13 second byte", last_byte, 8'h3E);
    pulse_done();
    chk(flags == 3'b000 && !dreq && !irq, "R8 done clears all", flags, 0);
    wait_intf(ok);
    chk(ok && last_byte == 8'h81, "R13 third byte", last_byte, 8'h81);
    chk(starts == s0 + 1, "R13 no restart", starts - s0, 1);
    s0 = stops;
    wr(2'd1, 8'b0000_0100);
    wait_stop(s0, ok);
    chk(ok, "R11 final stop", ok, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule